// File: doc/BRIEF.md
# Transceiver Status and Soft-Control Byte

This block builds the one status/control byte that a pluggable transceiver module shows to its host. It reads five external pin levels: the transmit-disable input, the two rate-select inputs, the transmit-fault output and the receive loss-of-signal output. Each level passes through a two-flop synchronizer. A snapshot of the synchronized levels is then taken on a periodic sampling tick, and that snapshot is what the byte reports. The tick period is a parameter and must be set well under the 100 ms bound that pin state is allowed to take to reach the byte.

The host writes the byte through a byte-wide write strobe and reads it on a continuously driven read bus. Only two bits can be written: a soft transmit-disable bit and a soft rate-select bit. Each is ORed with its hardware pin to form the effective control output. A per-feature parameter can build either soft bit without support. The bit then reads 0 and has no effect. A not-ready flag is set by reset and cleared by the first pulse of a measurement-complete input.

Top module: `xcvr_status_ctl`

## Requirements
- R1: After reset, with all pins low and settled, the byte reads 0x01, and both effective outputs are 0.
- R2: `txdis_eff_o` equals the synchronized transmit-disable pin ORed with the soft transmit-disable bit (byte bit 6). It follows a pin change within 2 clock cycles and a write in the cycle after the write.
- R3: `rate_sel_eff_o` equals the synchronized primary rate-select pin (`pin_rs0_i`) ORed with the soft rate-select bit (byte bit 3). A 1 means full bandwidth.
- R4: A write stores `wr_data_i[6]` in the soft transmit-disable bit and `wr_data_i[3]` in the soft rate-select bit. All other written bits are ignored.
- R5: Byte bits 7, 5, 4, 2 and 1 show `pin_txdis_i`, `pin_rs1_i`, `pin_rs0_i`, `pin_fault_i` and `pin_los_i`. Each matches its pin within TICK_DIV+3 cycles of a pin change, and changes only in the cycle after a sampling tick.
- R6: Without a write, both soft bits keep their value, and both reset to 0.
- R7: Byte bit 0 is 1 from reset until the first cycle in which `meas_done_i` is high. From the next cycle it reads 0 and stays 0 until the next reset.
- R8: With SOFT_TXDIS_EN=0, bit 6 reads 0 and `txdis_eff_o` follows only the pin. With SOFT_RATE_EN=0, bit 3 reads 0 and `rate_sel_eff_o` follows only the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_txdis_i | input | 1 | Asynchronous transmit-disable pin level |
| pin_rs1_i | input | 1 | Asynchronous second rate-select pin level |
| pin_rs0_i | input | 1 | Asynchronous primary rate-select pin level |
| pin_fault_i | input | 1 | Asynchronous transmit-fault pin level |
| pin_los_i | input | 1 | Asynchronous receive loss-of-signal pin level |
| wr_en_i | input | 1 | Write strobe for the status byte |
| wr_data_i | input | 8 | Write data; only bits 6 and 3 are used |
| rd_data_o | output | 8 | Current status byte |
| meas_done_i | input | 1 | First measurement complete |
| txdis_eff_o | output | 1 | Effective transmit disable |
| rate_sel_eff_o | output | 1 | Effective rate select |

## Verification
The bench covers every combination of the five pin levels with every combination of the two soft bits. It does this on the full build and on a build with both soft features removed. Each write sets the read-only bits to a changing pattern, so a design that let any of them through would show them in the byte. A design that ANDed instead of ORed the soft bit with its pin, or that exposed an unsupported soft bit, would give a wrong effective output in some of those cells. Repeated measurement-complete pulses and a second reset test the not-ready flag. A design that re-armed the flag or failed to clear it would read back the wrong bit 0.

// File: rtl/xcvr_status_pkg.sv
// Package: shared pin vector type and byte bit positions for the status byte.
// Assumes: the bit positions are fixed by host software that decodes the byte.
package xcvr_status_pkg;
    localparam int NUM_PINS = 5;

    typedef struct packed {
        logic txdis;
        logic rs1;
        logic rs0;
        logic fault;
        logic los;
    } pin_vec_t;

    localparam int BIT_TXDIS_PIN = 7;
    localparam int BIT_SOFT_TX   = 6;
    localparam int BIT_RS1_PIN   = 5;
    localparam int BIT_RS0_PIN   = 4;
    localparam int BIT_SOFT_RATE = 3;
    localparam int BIT_FAULT_PIN = 2;
    localparam int BIT_LOS_PIN   = 1;
    localparam int BIT_NOT_READY = 0;
endpackage

// File: rtl/xcvr_pin_sync.sv
// Module: multi-bit, multi-stage synchronizer for independent level signals.
// Assumes: each bit is an unrelated slow level, so per-bit sync is enough.
module xcvr_pin_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage: capture the raw asynchronous levels.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    // Remaining stages: shift the captured level along the chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/xcvr_sample_pacer.sv
// Module: periodic tick generator plus a snapshot of the synchronized pins.
// Assumes: TICK_DIV >= 2; the tick period times the clock period is far below 100 ms.
module xcvr_sample_pacer
    import xcvr_status_pkg::*;
#(
    parameter int TICK_DIV = 100000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  pin_vec_t pins_i,
    output pin_vec_t snap_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          tick;
    pin_vec_t      snap_q;

    assign tick = (cnt_q == LAST);

    // Free-running divider that wraps every TICK_DIV cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // Snapshot register: loads the pin levels on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    snap_q <= '0;
        else if (tick) snap_q <= pins_i;
    end

    assign snap_o = snap_q;

    AST_SNAP_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(snap_q)); // R5
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5
endmodule

// File: rtl/xcvr_soft_ctl.sv
// Module: host-writable soft-control bits and the sticky not-ready flag.
// Assumes: the write strobe and meas_done are synchronous to clk.
module xcvr_soft_ctl #(
    parameter bit SOFT_TXDIS_EN = 1'b1,
    parameter bit SOFT_RATE_EN  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en_i,
    input  logic wr_tx_bit_i,
    input  logic wr_rate_bit_i,
    input  logic meas_done_i,
    output logic soft_tx_o,
    output logic soft_rate_o,
    output logic not_ready_o
);
    logic not_ready_q;

    if (SOFT_TXDIS_EN) begin : g_soft_tx
        logic tx_q;
        // Soft transmit-disable bit: loads on a write, otherwise holds.
        always_ff @(posedge clk) begin
            if (!rst_n)       tx_q <= 1'b0;
            else if (wr_en_i) tx_q <= wr_tx_bit_i;
        end
        assign soft_tx_o = tx_q;
    end else begin : g_no_soft_tx
        assign soft_tx_o = 1'b0;
    end

    if (SOFT_RATE_EN) begin : g_soft_rate
        logic rate_q;
        // Soft rate-select bit: loads on a write, otherwise holds.
        always_ff @(posedge clk) begin
            if (!rst_n)       rate_q <= 1'b0;
            else if (wr_en_i) rate_q <= wr_rate_bit_i;
        end
        assign soft_rate_o = rate_q;
    end else begin : g_no_soft_rate
        assign soft_rate_o = 1'b0;
    end

    // Not-ready flag: set by reset, cleared for good by the first meas_done.
    always_ff @(posedge clk) begin
        if (!rst_n)          not_ready_q <= 1'b1;
        else if (meas_done_i) not_ready_q <= 1'b0;
    end

    assign not_ready_o = not_ready_q;

    AST_NRDY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !not_ready_q |=> !not_ready_q); // R7
    AST_NRDY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done_i |=> !not_ready_q); // R7
    AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ($stable(soft_tx_o) && $stable(soft_rate_o))); // R6
endmodule

// File: rtl/xcvr_status_ctl.sv
// Module: top of the transceiver status/control byte.
// Assumes: pins are asynchronous levels; writes, reads and meas_done are on clk.
module xcvr_status_ctl
    import xcvr_status_pkg::*;
#(
    parameter int TICK_DIV      = 100000,
    parameter int SYNC_STAGES   = 2,
    parameter bit SOFT_TXDIS_EN = 1'b1,
    parameter bit SOFT_RATE_EN  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_txdis_i,
    input  logic       pin_rs1_i,
    input  logic       pin_rs0_i,
    input  logic       pin_fault_i,
    input  logic       pin_los_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    input  logic       meas_done_i,
    output logic       txdis_eff_o,
    output logic       rate_sel_eff_o
);
    pin_vec_t raw_pins;
    pin_vec_t sync_pins;
    pin_vec_t snap_pins;
    logic     soft_tx;
    logic     soft_rate;
    logic     not_ready;

    assign raw_pins = '{txdis: pin_txdis_i, rs1: pin_rs1_i, rs0: pin_rs0_i,
                        fault: pin_fault_i, los: pin_los_i};

    xcvr_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_pins),
        .sync_o  (sync_pins)
    );

    xcvr_sample_pacer #(.TICK_DIV(TICK_DIV)) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (sync_pins),
        .snap_o (snap_pins)
    );

    xcvr_soft_ctl #(.SOFT_TXDIS_EN(SOFT_TXDIS_EN), .SOFT_RATE_EN(SOFT_RATE_EN)) u_soft (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en_i),
        .wr_tx_bit_i   (wr_data_i[BIT_SOFT_TX]),
        .wr_rate_bit_i (wr_data_i[BIT_SOFT_RATE]),
        .meas_done_i   (meas_done_i),
        .soft_tx_o     (soft_tx),
        .soft_rate_o   (soft_rate),
        .not_ready_o   (not_ready)
    );

    // Effective controls: soft request ORed with the synchronized pin.
    always_comb begin
        txdis_eff_o    = sync_pins.txdis | soft_tx;
        rate_sel_eff_o = sync_pins.rs0   | soft_rate;
    end

    // Status byte assembly at the fixed decoded bit positions.
    always_comb begin
        rd_data_o                = '0;
        rd_data_o[BIT_TXDIS_PIN] = snap_pins.txdis;
        rd_data_o[BIT_SOFT_TX]   = soft_tx;
        rd_data_o[BIT_RS1_PIN]   = snap_pins.rs1;
        rd_data_o[BIT_RS0_PIN]   = snap_pins.rs0;
        rd_data_o[BIT_SOFT_RATE] = soft_rate;
        rd_data_o[BIT_FAULT_PIN] = snap_pins.fault;
        rd_data_o[BIT_LOS_PIN]   = snap_pins.los;
        rd_data_o[BIT_NOT_READY] = not_ready;
    end

    AST_SOFT_TX_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[BIT_SOFT_TX] |-> txdis_eff_o); // R2
    AST_SOFT_RATE_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[BIT_SOFT_RATE] |-> rate_sel_eff_o); // R3
    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && SOFT_TXDIS_EN) |=> (rd_data_o[BIT_SOFT_TX] == $past(wr_data_i[BIT_SOFT_TX]))); // R4
    AST_NOSOFT_TX: assert property (@(posedge clk) disable iff (!rst_n)
        !SOFT_TXDIS_EN |-> !rd_data_o[BIT_SOFT_TX]); // R8
endmodule

// File: tb/xcvr_status_ctl_bench.sv
module xcvr_status_ctl_bench;
    localparam int TDIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] pins = '0;     // {txdis, rs1, rs0, fault, los}
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       meas_done = 1'b0;
    logic [7:0] rd_a, rd_b;
    logic       tx_a, tx_b, rt_a, rt_b;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xcvr_status_ctl #(.TICK_DIV(TDIV)) u_xcvr_status_ctl (
        .clk(clk), .rst_n(rst_n),
        .pin_txdis_i(pins[4]), .pin_rs1_i(pins[3]), .pin_rs0_i(pins[2]),
        .pin_fault_i(pins[1]), .pin_los_i(pins[0]),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_a),
        .meas_done_i(meas_done), .txdis_eff_o(tx_a), .rate_sel_eff_o(rt_a));

    xcvr_status_ctl #(.TICK_DIV(TDIV), .SOFT_TXDIS_EN(1'b0), .SOFT_RATE_EN(1'b0)) u_nosoft (
        .clk(clk), .rst_n(rst_n),
        .pin_txdis_i(pins[4]), .pin_rs1_i(pins[3]), .pin_rs0_i(pins[2]),
        .pin_fault_i(pins[1]), .pin_los_i(pins[0]),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_b),
        .meas_done_i(meas_done), .txdis_eff_o(tx_b), .rate_sel_eff_o(rt_b));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [7:0] exp_byte(input logic [4:0] p, input logic st,
                                            input logic sr, input logic nr);
        return {p[4], st, p[3], p[2], sr, p[1], p[0], nr};
    endfunction

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(TDIV + 4);
        // R1 reset state
        chk("R1 byte", rd_a, 8'h01);
        chk("R1 byte nosoft", rd_b, 8'h01);
        chk("R1 eff", {6'b0, tx_a, rt_a}, 8'h00);
        // R7 flag holds while meas_done low, clears after first pulse
        wait_neg(20);
        chk("R7 before done", {7'b0, rd_a[0]}, 8'h01);
        meas_done = 1'b1;
        @(negedge clk);
        meas_done = 1'b0;
        chk("R7 cleared", {7'b0, rd_a[0]}, 8'h00);
        meas_done = 1'b1;
        wait_neg(2);
        meas_done = 1'b0;
        wait_neg(5);
        chk("R7 stays low", {7'b0, rd_a[0]}, 8'h00);

        // Exhaustive sweep: pins x soft bits, two builds (R2 R3 R4 R5 R6 R8)
        for (int i = 0; i < 128; i++) begin
            logic [4:0] p;
            logic st, sr;
            logic [7:0] w;
            p  = i[4:0];
            st = i[5];
            sr = i[6];
            w  = (8'(i * 37) & ~8'h48) | {1'b0, st, 2'b0, sr, 3'b0};
            pins = p;
            do_write(w);
            // R2 R3: effective outputs settle within 2 cycles of pin change
            wait_neg(2);
            chk("R2 txdis eff", {7'b0, tx_a}, {7'b0, p[4] | st});
            chk("R3 rate eff", {7'b0, rt_a}, {7'b0, p[2] | sr});
            chk("R8 txdis eff nosoft", {7'b0, tx_b}, {7'b0, p[4]});
            chk("R8 rate eff nosoft", {7'b0, rt_b}, {7'b0, p[2]});
            wait_neg(TDIV + 2);
            // R4 R5: byte shows pins, written soft bits only
            chk("R4 R5 byte", rd_a, exp_byte(p, st, sr, 1'b0));
            chk("R5 R8 byte nosoft", rd_b, exp_byte(p, 1'b0, 1'b0, 1'b0));
            // R6: soft bits hold with no further write
            wait_neg(TDIV * 2);
            chk("R6 hold", rd_a, exp_byte(p, st, sr, 1'b0));
        end

        // R1 R6 R7: second reset re-arms flag and clears soft bits
        do_write(8'h48);
        pins = '0;
        rst_n = 1'b0;
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(TDIV + 4);
        chk("R7 R6 after reset", rd_a, 8'h01);
        chk("R1 eff after reset", {6'b0, tx_a, rt_a}, 8'h00);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule